// File: doc/BRIEF.md
# Dual-Stream Transport Packet PID Gate

This block sits on two MPEG transport streams, each arriving one byte per accepted cycle, and forwards or discards whole 188-byte packets according to the 13-bit packet identifier (PID) they carry. Each stream has its own drop bitmap with one bit per PID value, 8192 bits stored as 1024 bytes. Both bitmaps live in one shared byte memory. A 1 in a PID's bit discards the packet and a 0 forwards it. PIDs 0 to 31 are always forwarded.

Each stream first locks onto the packet grid. It looks for the sync byte 0x47 and only trusts it after a second 0x47 appears exactly one packet later. Once locked, it reads the PID from bytes 1 and 2 of each packet and looks the PID up in its own bitmap. It then releases the packet's bytes through a fixed two-byte delay line. Because of this delay, the verdict is known before the first byte leaves.

A host edits the bitmaps through three small registers: a low address byte, a high address register that also picks the bank, and a data port. A single bit is changed by read-modify-write of the byte that holds it. At reset every bitmap blocks all PIDs above 31.

Top module: `pidf_top`

## Requirements
- R1: After reset, bytes 0 to 3 of both banks read 0x00 and bytes 4 to 1023 of both banks read 0xFF, so every PID of 32 or more is blocked.
- R2: Host register select 0 holds the byte address bits 7:0. Select 1 holds byte address bits 9:8 in its bits 1:0 and the bank number in its bit 2, and reads back with bits 7:3 zero. Select 3 reads 0 and ignores writes. Both address registers read back what was written.
- R3: A host read of the data port (select 2) that is accepted on a clock edge raises host_rvalid in the following cycle, with host_rdata holding the addressed byte. An accepted write to the data port replaces that byte.
- R4: Host writes to bytes 0 to 3 of either bank are ignored, and those bytes keep reading 0x00.
- R5: In any cycle in which either stream performs a bitmap lookup, host_ready is low and the host access is not taken. The host access is taken in the first cycle without a lookup.
- R6: From the hunting state, a stream forwards nothing until a 0x47 is seen and a second 0x47 arrives exactly 188 bytes later. The packet that starts with the second 0x47 is the first one eligible to pass.
- R7: The PID is {byte1[4:0], byte2}. Its drop bit is bit PID[2:0] of byte PID[12:3] in the stream's bank. A 1 drops the whole packet and a 0 forwards the whole packet.
- R8: Packets with a PID below 32 are forwarded whatever the bitmap holds.
- R9: Stream 0 looks up bank 0 and stream 1 looks up bank 1. A bit set in one bank has no effect on the other stream.
- R10: In the locked state, a packet whose first byte is not 0x47 is dropped, and the stream returns to hunting.
- R11: Forwarded bytes leave unmodified and in input order. Each one is output in the cycle after the input byte two positions behind it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_in_valid | input | 2 | Per-stream input byte strobe |
| st_in_data | input | 16 | Per-stream input byte, stream s in bits 8s+7:8s |
| st_out_valid | output | 2 | Per-stream forwarded byte strobe |
| st_out_data | output | 16 | Per-stream forwarded byte |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | Host access is a write |
| host_sel | input | 2 | Host register select: 0 low address, 1 high address/bank, 2 data port, 3 unused |
| host_wdata | input | 8 | Host write byte |
| host_ready | output | 1 | Host access taken this cycle when high |
| host_rdata | output | 8 | Host read byte, valid with host_rvalid |
| host_rvalid | output | 1 | Read result strobe, one cycle after an accepted read |

## Verification
The assertions assume the host holds its request until host_ready is high. They also assume stream bytes come only with their strobe, at most one per cycle per stream. The stimulus drives every host access from one task that keeps the request up through a full clock edge. Stream bytes are presented one per cycle and always as whole 188-byte packets. A dropped terminating packet with a PID of 0x1FFF follows each group, so that the two-byte delay line is flushed before counts are compared.

// File: rtl/pidf_pkg.sv
package pidf_pkg;
    localparam int          PKT_LEN        = 188;
    localparam logic [7:0]  SYNC_BYTE      = 8'h47;
    localparam int          PID_W          = 13;
    localparam int          LOW_PASS_LIMIT = 32;
    localparam int          BANK_BYTES     = (1 << PID_W) / 8;
    localparam int          LOW_BYTES      = LOW_PASS_LIMIT / 8;
    localparam int          LOOK_IDX       = 2;   // byte carrying PID low bits

    typedef enum logic [1:0] {SY_HUNT, SY_CONFIRM, SY_LOCKED} sync_e;
    typedef enum logic [1:0] {
        REG_ADDR_LO = 2'd0,
        REG_ADDR_HI = 2'd1,
        REG_DATA    = 2'd2,
        REG_NONE    = 2'd3
    } hreg_e;

    typedef struct packed {
        logic       live;   // byte belongs to a locked packet
        logic [7:0] data;
    } slot_t;

    function automatic logic [PID_W-1:0] pid_of(input logic [7:0] b1, input logic [7:0] b2);
        return {b1[4:0], b2};
    endfunction
endpackage

// File: rtl/pidf_bitmap.sv
module pidf_bitmap
    import pidf_pkg::*;
#(
    parameter int NSTREAM = 2,
    parameter int BADDR_W = $clog2(BANK_BYTES)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NSTREAM-1:0]         lk_req,
    input  logic [NSTREAM*BADDR_W-1:0] lk_addr,
    output logic [NSTREAM*8-1:0]       lk_byte,
    input  logic                       host_req,
    input  logic                       host_we,
    input  logic [1:0]                 host_sel,
    input  logic [7:0]                 host_wdata,
    output logic                       host_ready,
    output logic [7:0]                 host_rdata,
    output logic                       host_rvalid
);
    localparam int DEPTH = NSTREAM * BANK_BYTES;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int HI_W  = IDX_W - 8;

    logic [7:0]      mem [DEPTH];
    logic [7:0]      addr_lo;
    logic [HI_W-1:0] addr_hi;
    logic [IDX_W-1:0] host_idx;
    logic            acc, low_byte;

    for (genvar s = 0; s < NSTREAM; s++) begin : g_look
        logic [IDX_W-1:0] li;
        assign li = IDX_W'(s * BANK_BYTES) + IDX_W'(lk_addr[s*BADDR_W +: BADDR_W]);
        assign lk_byte[s*8 +: 8] = mem[li];
    end

    assign host_ready = ~|lk_req;
    assign acc        = host_req && host_ready;
    assign host_idx   = {addr_hi, addr_lo};
    assign low_byte   = host_idx[BADDR_W-1:0] < BADDR_W'(LOW_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= ((i % BANK_BYTES) < LOW_BYTES) ? 8'h00 : 8'hFF;
            addr_lo     <= '0;
            addr_hi     <= '0;
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            host_rvalid <= acc && !host_we;
            if (acc) begin
                case (hreg_e'(host_sel))
                    REG_ADDR_LO: if (host_we) addr_lo <= host_wdata;
                                 else host_rdata <= addr_lo;
                    REG_ADDR_HI: if (host_we) addr_hi <= host_wdata[HI_W-1:0];
                                 else host_rdata <= 8'(addr_hi);
                    REG_DATA: begin
                        if (host_we) begin
                            if (!low_byte) mem[host_idx] <= host_wdata;
                        end else begin
                            host_rdata <= mem[host_idx];
                        end
                    end
                    default: if (!host_we) host_rdata <= 8'h00;
                endcase
            end
        end
    end

    for (genvar s = 0; s < NSTREAM; s++) begin : g_lowchk
        for (genvar b = 0; b < LOW_BYTES; b++) begin : g_byte
            assert_low_zero_R4: assert property (@(posedge clk) disable iff (rst)
                mem[s*BANK_BYTES + b] == 8'h00);
        end
    end

    assert_read_answers_R3: assert property (@(posedge clk) disable iff (rst)
        (host_req && host_ready && !host_we) |=> host_rvalid);

    assert_rvalid_cause_R5: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |-> $past(host_req && host_ready && !host_we));
endmodule

// File: rtl/pidf_stream.sv
module pidf_stream
    import pidf_pkg::*;
#(
    parameter int PLEN    = PKT_LEN,
    parameter int BADDR_W = $clog2(BANK_BYTES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    output logic               lk_req,
    output logic [BADDR_W-1:0] lk_addr,
    input  logic [7:0]         lk_byte,
    output logic               out_valid,
    output logic [7:0]         out_data
);
    localparam int IDX_W = $clog2(PLEN);
    localparam int DLY   = LOOK_IDX;

    sync_e            state, nxt_state;
    logic [IDX_W-1:0] idx;
    logic [7:0]       b1;
    logic             keep, live_in, at_start, verdict, leave_pass;
    logic [PID_W-1:0] pid;
    slot_t            line [DLY];

    assign at_start = (idx == '0);

    always_comb begin
        nxt_state = state;
        live_in   = 1'b0;
        case (state)
            SY_HUNT:
                if (in_valid && in_data == SYNC_BYTE) nxt_state = SY_CONFIRM;
            SY_CONFIRM: begin
                if (in_valid && at_start)
                    nxt_state = (in_data == SYNC_BYTE) ? SY_LOCKED : SY_HUNT;
                live_in = in_valid && at_start && in_data == SYNC_BYTE;
            end
            SY_LOCKED: begin
                if (in_valid && at_start && in_data != SYNC_BYTE) nxt_state = SY_HUNT;
                live_in = in_valid && !(at_start && in_data != SYNC_BYTE);
            end
            default: nxt_state = SY_HUNT;
        endcase
    end

    assign pid        = pid_of(b1, in_data);
    assign lk_req     = live_in && state == SY_LOCKED && idx == IDX_W'(LOOK_IDX);
    assign lk_addr    = pid[PID_W-1:3];
    assign verdict    = (pid < PID_W'(LOW_PASS_LIMIT)) || !lk_byte[pid[2:0]];
    assign leave_pass = line[DLY-1].live && (lk_req ? verdict : keep);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SY_HUNT;
            idx       <= '0;
            b1        <= '0;
            keep      <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            for (int i = 0; i < DLY; i++) line[i] <= '0;
        end else begin
            out_valid <= 1'b0;
            if (in_valid) begin
                state <= nxt_state;
                if (state == SY_HUNT)
                    idx <= (in_data == SYNC_BYTE) ? IDX_W'(1) : '0;
                else if (nxt_state == SY_HUNT)
                    idx <= '0;
                else
                    idx <= (idx == IDX_W'(PLEN-1)) ? '0 : idx + 1'b1;
                if (idx == IDX_W'(1)) b1 <= in_data;
                if (lk_req) keep <= verdict;
                out_valid <= leave_pass;
                out_data  <= line[DLY-1].data;
                for (int i = DLY-1; i > 0; i--) line[i] <= line[i-1];
                line[0] <= '{live: live_in, data: in_data};
            end
        end
    end

    assert_idx_range_R6: assert property (@(posedge clk) disable iff (rst)
        idx < IDX_W'(PLEN));

    assert_lookup_spacing_R7: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> !lk_req);

    assert_out_follows_in_R11: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));
endmodule

// File: rtl/pidf_top.sv
module pidf_top
    import pidf_pkg::*;
#(
    parameter int PLEN = PKT_LEN
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  st_in_valid,
    input  logic [15:0] st_in_data,
    output logic [1:0]  st_out_valid,
    output logic [15:0] st_out_data,
    input  logic        host_req,
    input  logic        host_we,
    input  logic [1:0]  host_sel,
    input  logic [7:0]  host_wdata,
    output logic        host_ready,
    output logic [7:0]  host_rdata,
    output logic        host_rvalid
);
    localparam int NSTREAM = 2;
    localparam int BADDR_W = $clog2(BANK_BYTES);

    logic [NSTREAM-1:0]         lk_req;
    logic [NSTREAM*BADDR_W-1:0] lk_addr;
    logic [NSTREAM*8-1:0]       lk_byte;

    for (genvar s = 0; s < NSTREAM; s++) begin : g_stream
        pidf_stream #(.PLEN(PLEN), .BADDR_W(BADDR_W)) i_stream (
            .clk      (clk),
            .rst      (rst),
            .in_valid (st_in_valid[s]),
            .in_data  (st_in_data[s*8 +: 8]),
            .lk_req   (lk_req[s]),
            .lk_addr  (lk_addr[s*BADDR_W +: BADDR_W]),
            .lk_byte  (lk_byte[s*8 +: 8]),
            .out_valid(st_out_valid[s]),
            .out_data (st_out_data[s*8 +: 8])
        );
    end

    pidf_bitmap #(.NSTREAM(NSTREAM), .BADDR_W(BADDR_W)) i_bitmap (
        .clk        (clk),
        .rst        (rst),
        .lk_req     (lk_req),
        .lk_addr    (lk_addr),
        .lk_byte    (lk_byte),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_ready (host_ready),
        .host_rdata (host_rdata),
        .host_rvalid(host_rvalid)
    );
endmodule

// File: tb/test_pidf_top.sv
module test_pidf_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 22;
    localparam int PLEN = 188;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  st_in_valid = '0;
    logic [15:0] st_in_data = '0;
    logic [1:0]  st_out_valid;
    logic [15:0] st_out_data;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [1:0]  host_sel = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ready, host_rvalid;
    logic [7:0]  host_rdata;

    int n_chk = 0, n_bad = 0;
    int ocnt [2];
    logic [7:0] cap [2][3];
    logic done = 1'b0;
    logic [7:0] rd;

    // {sel[1:0], we, wdata[7:0], check, expected[7:0]}
    localparam logic [19:0] VEC [NVEC] = '{
        {2'd0, 1'b1, 8'h00, 1'b0, 8'h00},
        {2'd1, 1'b1, 8'h00, 1'b0, 8'h00},
        {2'd2, 1'b0, 8'h00, 1'b1, 8'h00},   // R1 byte 0 clear
        {2'd0, 1'b1, 8'h04, 1'b0, 8'h00},
        {2'd2, 1'b0, 8'h00, 1'b1, 8'hFF},   // R1 byte 4 blocks
        {2'd0, 1'b1, 8'hFF, 1'b0, 8'h00},
        {2'd1, 1'b1, 8'h03, 1'b0, 8'h00},
        {2'd2, 1'b0, 8'h00, 1'b1, 8'hFF},   // R1 byte 1023
        {2'd0, 1'b1, 8'h02, 1'b0, 8'h00},
        {2'd1, 1'b1, 8'h04, 1'b0, 8'h00},
        {2'd2, 1'b1, 8'h55, 1'b0, 8'h00},
        {2'd2, 1'b0, 8'h00, 1'b1, 8'h00},   // R4 write to byte 2 ignored
        {2'd0, 1'b1, 8'h10, 1'b0, 8'h00},
        {2'd2, 1'b1, 8'h5A, 1'b0, 8'h00},
        {2'd2, 1'b0, 8'h00, 1'b1, 8'h5A},   // R3 write then read
        {2'd0, 1'b0, 8'h00, 1'b1, 8'h10},   // R2 low address readback
        {2'd1, 1'b0, 8'h00, 1'b1, 8'h04},   // R2 high address readback
        {2'd1, 1'b1, 8'hFF, 1'b0, 8'h00},
        {2'd1, 1'b0, 8'h00, 1'b1, 8'h07},   // R2 upper bits read zero
        {2'd3, 1'b0, 8'h00, 1'b1, 8'h00},   // R2 unused select
        {2'd1, 1'b1, 8'h00, 1'b0, 8'h00},
        {2'd2, 1'b0, 8'h00, 1'b1, 8'hFF}    // R9 bank 0 untouched
    };
    localparam int VREQ [NVEC] = '{0,0,1,0,1,0,0,1,0,0,0,4,0,0,3,2,2,0,2,2,0,9};

    pidf_top i_pidf_top (
        .clk(clk), .rst(rst),
        .st_in_valid(st_in_valid), .st_in_data(st_in_data),
        .st_out_valid(st_out_valid), .st_out_data(st_out_data),
        .host_req(host_req), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        #1;
        for (int s = 0; s < 2; s++) begin
            if (!rst && st_out_valid[s]) begin
                if (ocnt[s] < 3) cap[s][ocnt[s]] = st_out_data[s*8 +: 8];
                ocnt[s] = ocnt[s] + 1;
            end
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic host_acc(input logic [1:0] sel, input logic we, input logic [7:0] wd,
                            output logic [7:0] r);
        @(negedge clk);
        host_req = 1'b1; host_sel = sel; host_we = we; host_wdata = wd;
        @(posedge clk); #1;
        host_req = 1'b0;
        r = host_rdata;
    endtask

    task automatic host_put(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] d);
        logic [7:0] dummy;
        host_acc(2'd1, 1'b1, hi, dummy);
        host_acc(2'd0, 1'b1, lo, dummy);
        host_acc(2'd2, 1'b1, d, dummy);
    endtask

    task automatic send_byte(input int s, input logic [7:0] b);
        @(negedge clk);
        st_in_valid[s] = 1'b1;
        st_in_data[s*8 +: 8] = b;
        @(posedge clk); #1;
        st_in_valid[s] = 1'b0;
    endtask

    function automatic logic [7:0] pkt_byte(input int k, input logic [12:0] pid, input logic [7:0] b0);
        if (k == 0) return b0;
        if (k == 1) return {3'b000, pid[12:8]};
        if (k == 2) return pid[7:0];
        return 8'h80 | 8'(k[6:0]);
    endfunction

    task automatic send_pkt(input int s, input logic [12:0] pid, input logic [7:0] b0);
        for (int k = 0; k < PLEN; k++) send_byte(s, pkt_byte(k, pid, b0));
    endtask

    task automatic clear_counts();
        ocnt[0] = 0; ocnt[1] = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        clear_counts();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check(host_ready === 1'b1, "R5 idle ready", int'(host_ready), 1);
        check(host_rvalid === 1'b0, "R3 reset rvalid", int'(host_rvalid), 0);
        check(st_out_valid === 2'b00, "R11 reset output", int'(st_out_valid), 0);

        for (int v = 0; v < NVEC; v++) begin
            host_acc(VEC[v][19:18], VEC[v][17], VEC[v][16:9], rd);
            if (VEC[v][8]) begin
                check(rd === VEC[v][7:0], $sformatf("R%0d vector %0d", VREQ[v], v),
                      int'(rd), int'(VEC[v][7:0]));
                check(host_rvalid === 1'b1, "R3 rvalid", int'(host_rvalid), 1);
            end
        end

        host_put(8'h00, 8'h20, 8'hFE);   // bank0: PID 0x100 passes, 0x101 drops
        host_put(8'h04, 8'h21, 8'h00);   // bank1: PIDs 0x108..0x10F pass

        // R6: confirm packet dropped, second aligned packet passes
        clear_counts();
        send_pkt(0, 13'h100, 8'h47);
        send_pkt(0, 13'h100, 8'h47);
        send_pkt(0, 13'h1FFF, 8'h47);
        check(ocnt[0] == PLEN, "R6 lock needs two syncs", ocnt[0], PLEN);
        check(cap[0][0] == 8'h47 && cap[0][1] == 8'h01 && cap[0][2] == 8'h00,
              "R11 bytes in order", int'({cap[0][0], cap[0][1], cap[0][2]}), 'h470100);

        // R7: drop bit set vs clear
        clear_counts();
        send_pkt(0, 13'h101, 8'h47);
        send_pkt(0, 13'h1FFF, 8'h47);
        check(ocnt[0] == 0, "R7 dropped PID", ocnt[0], 0);
        clear_counts();
        send_pkt(0, 13'h100, 8'h47);
        send_pkt(0, 13'h100, 8'h47);
        send_pkt(0, 13'h1FFF, 8'h47);
        check(ocnt[0] == 2*PLEN, "R7 passed PID", ocnt[0], 2*PLEN);

        // R8: low PIDs pass, 0x20 blocked by reset map
        clear_counts();
        send_pkt(0, 13'h005, 8'h47);
        send_pkt(0, 13'h01F, 8'h47);
        send_pkt(0, 13'h020, 8'h47);
        send_pkt(0, 13'h1FFF, 8'h47);
        check(ocnt[0] == 2*PLEN, "R8 low PIDs pass", ocnt[0], 2*PLEN);

        // R10: bad start byte loses lock, re-lock takes two packets
        clear_counts();
        send_pkt(0, 13'h100, 8'h00);
        send_pkt(0, 13'h100, 8'h47);
        send_pkt(0, 13'h100, 8'h47);
        send_pkt(0, 13'h1FFF, 8'h47);
        check(ocnt[0] == PLEN, "R10 lock loss", ocnt[0], PLEN);

        // R9: stream 1 uses bank 1
        clear_counts();
        send_pkt(1, 13'h10A, 8'h47);
        send_pkt(1, 13'h10A, 8'h47);
        send_pkt(1, 13'h100, 8'h47);
        send_pkt(1, 13'h1FFF, 8'h47);
        check(ocnt[1] == PLEN, "R9 stream1 bank1", ocnt[1], PLEN);
        send_pkt(0, 13'h10A, 8'h47);
        send_pkt(0, 13'h1FFF, 8'h47);
        check(ocnt[0] == 0, "R9 stream0 bank0", ocnt[0], 0);

        // R5: host write collides with a lookup
        host_acc(2'd0, 1'b1, 8'h40, rd);
        clear_counts();
        send_byte(0, 8'h47);
        send_byte(0, 8'h01);
        @(negedge clk);
        st_in_valid[0] = 1'b1; st_in_data[7:0] = 8'h00;
        host_req = 1'b1; host_sel = 2'd2; host_we = 1'b1; host_wdata = 8'h33;
        #1;
        check(host_ready === 1'b0, "R5 stall on lookup", int'(host_ready), 0);
        @(posedge clk); #1;
        st_in_valid[0] = 1'b0;
        @(negedge clk); #1;
        check(host_ready === 1'b1, "R5 ready after lookup", int'(host_ready), 1);
        @(posedge clk); #1;
        host_req = 1'b0;
        for (int k = 3; k < PLEN; k++) send_byte(0, pkt_byte(k, 13'h100, 8'h47));
        send_pkt(0, 13'h1FFF, 8'h47);
        check(ocnt[0] == PLEN, "R5 lookup unaffected", ocnt[0], PLEN);
        host_acc(2'd2, 1'b0, 8'h00, rd);
        check(rd === 8'h33, "R5 stalled write lands once", int'(rd), 'h33);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule